// File: doc/BRIEF.md
# Supply-Loss Access Guard for a Byte-Wide Static RAM

This block sits between a host bus and a byte-wide static RAM and decides, cycle by cycle, whether host accesses may reach the memory. Two comparator flags describe the supply. One says the supply is below the deselect level. The other says it is below the level at which the backup cell must take over. Both flags are asynchronous and are brought into the clock domain before any use.

With a healthy supply, chip-enable, write-enable and output-enable pass straight through, and the RAM behaves like an ordinary static memory. When the supply sags, an access that is already under way may run to its end, but only within a bounded number of cycles. After that the memory is cut off and write-protected. Access does not resume at once when the supply comes back: the block first holds protection for a stabilization period. A second supply dip during that period sends it back to the protected state. The block also drives a battery-select line that follows the low-supply flag.

All host control inputs are active high. The current sequencer state is available on a status port with this encoding: 0 = normal, 1 = draining an access, 2 = protected, 3 = recovering.

Top module: `pfail_guard`

## Requirements
- R1: While reset is asserted the state is protected (2). ram_ce_o, ram_we_o, ram_oe_o and dq_drive_o are all 0.
- R2: In the normal state (0), the gated controls follow the host directly:
  - ram_ce_o equals host_ce_i;
  - ram_we_o equals host_ce_i and host_we_i;
  - ram_oe_o equals host_ce_i and host_oe_i;
  - dq_drive_o equals host_ce_i and host_oe_i and not host_we_i.
- R3: below_desel_i passes through a two-flop synchronizer. The state first reacts to a change of this input at the third rising clock edge after the change.
- R4: If the deselect flag is seen in the normal state while host_ce_i is 0, the next state is protected (2).
- R5: If the deselect flag is seen in the normal state while host_ce_i is 1, the next state is drain (1). The access continues with its controls still passed through.
- R6: The drain state lasts at most T_WP cycles. After T_WP cycles, protection (2) is forced even if host_ce_i is still 1.
- R7: In the protected (2) and recovering (3) states, host inputs are ignored: ram_ce_o, ram_we_o, ram_oe_o and dq_drive_o stay 0, so the data bus is undriven.
- R8: Once the synchronized deselect flag clears in the protected state, the block spends exactly T_ER cycles in the recovering state (3) and then returns to normal (0).
- R9: If the deselect flag is seen again during recovery, the state returns to protected (2). The next recovery starts again from a full T_ER cycles.
- R10: batt_sel_o equals below_swo_i delayed through a two-flop synchronizer. It changes at the second rising edge after the input changes.
- R11: state_o reports the sequencer state with the encoding 0 normal, 1 drain, 2 protected, 3 recovering.
- R12: In the drain state, host_ce_i going to 0 ends the access. The gated controls drop in the same cycle and the next state is protected. A later host_ce_i assertion does not reach the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; enters protected state |
| below_desel_i | input | 1 | Asynchronous flag: supply below deselect level |
| below_swo_i | input | 1 | Asynchronous flag: supply below battery switchover level |
| host_ce_i | input | 1 | Host chip-enable, active high |
| host_we_i | input | 1 | Host write-enable, active high |
| host_oe_i | input | 1 | Host output-enable, active high |
| ram_ce_o | output | 1 | Gated chip-enable to the RAM |
| ram_we_o | output | 1 | Gated write-enable to the RAM |
| ram_oe_o | output | 1 | Gated output-enable to the RAM |
| dq_drive_o | output | 1 | Data bus output-drive enable; 0 means high impedance |
| batt_sel_o | output | 1 | Battery-select, high while supply is below switchover |
| state_o | output | 2 | Sequencer state: 0 normal, 1 drain, 2 protected, 3 recovering |

## Verification
The assertions check several properties on every cycle:
- no gated control is active in the protected or recovering state;
- a write never appears without chip-enable, and the data bus is never driven during a write;
- the drain state never lasts beyond T_WP cycles, and it is only entered or held while chip-enable was high;
- every return to normal follows exactly T_ER cycles of recovery and never skips that state.

The bench scenarios cover what depends on stimulus timing:
- the exact edge on which each synchronized flag takes effect;
- pass-through under different control patterns;
- an access ending early versus one cut off at the limit;
- cancelled recovery restarting its full delay;
- battery-select latency.

// File: rtl/pfail_pkg.sv
package pfail_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROT    = 2'd2,
        ST_RECOVER = 2'd3
    } pf_state_e;
endpackage

// File: rtl/pfail_sync.sv
// Multi-bit two-flop synchronizer with a per-bit reset value.
module pfail_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end
        assign q_o[i] = sync_q;
    end
endmodule

// File: rtl/pfail_gate.sv
// Gates host strobes onto the RAM pins when access is permitted.
module pfail_gate (
    input  logic en_i,
    input  logic ce_i,
    input  logic we_i,
    input  logic oe_i,
    output logic ram_ce_o,
    output logic ram_we_o,
    output logic ram_oe_o,
    output logic dq_drive_o
);
    logic sel;
    assign sel        = en_i & ce_i;
    assign ram_ce_o   = sel;
    assign ram_we_o   = sel & we_i;
    assign ram_oe_o   = sel & oe_i;
    assign dq_drive_o = sel & oe_i & ~we_i;
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard #(
    parameter int T_WP = 16,
    parameter int T_ER = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       below_desel_i,
    input  logic       below_swo_i,
    input  logic       host_ce_i,
    input  logic       host_we_i,
    input  logic       host_oe_i,
    output logic       ram_ce_o,
    output logic       ram_we_o,
    output logic       ram_oe_o,
    output logic       dq_drive_o,
    output logic       batt_sel_o,
    output logic [1:0] state_o
);
    import pfail_pkg::*;

    localparam int TMAX = (T_WP > T_ER) ? T_WP : T_ER;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] WP_LOAD = CW'(T_WP - 1);
    localparam logic [CW-1:0] ER_LOAD = CW'(T_ER - 1);

    typedef struct packed {
        pf_state_e     st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [1:0] flags_s;
    logic       desel_s;
    logic       pass_en;

    // bit 0 = deselect flag (resets asserted), bit 1 = switchover flag
    pfail_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({below_swo_i, below_desel_i}),
        .q_o   (flags_s)
    );

    assign desel_s    = flags_s[0];
    assign batt_sel_o = flags_s[1];

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_NORMAL: begin
                if (desel_s) begin
                    if (host_ce_i) begin
                        seq_d.st  = ST_DRAIN;
                        seq_d.cnt = WP_LOAD;
                    end else begin
                        seq_d.st  = ST_PROT;
                    end
                end
            end
            ST_DRAIN: begin
                if (!host_ce_i || seq_q.cnt == '0) begin
                    seq_d.st = ST_PROT;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_PROT: begin
                if (!desel_s) begin
                    seq_d.st  = ST_RECOVER;
                    seq_d.cnt = ER_LOAD;
                end
            end
            ST_RECOVER: begin
                if (desel_s) begin
                    seq_d.st = ST_PROT;
                end else if (seq_q.cnt == '0) begin
                    seq_d.st = ST_NORMAL;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_PROT;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pass_en = (seq_q.st == ST_NORMAL) || (seq_q.st == ST_DRAIN);
    assign state_o = seq_q.st;

    pfail_gate u_gate (
        .en_i       (pass_en),
        .ce_i       (host_ce_i),
        .we_i       (host_we_i),
        .oe_i       (host_oe_i),
        .ram_ce_o   (ram_ce_o),
        .ram_we_o   (ram_we_o),
        .ram_oe_o   (ram_oe_o),
        .dq_drive_o (dq_drive_o)
    );
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
    parameter int T_WP = 16,
    parameter int T_ER = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ce_i,
    input logic       ram_ce_o,
    input logic       ram_we_o,
    input logic       ram_oe_o,
    input logic       dq_drive_o,
    input logic [1:0] state_o
);
    import pfail_pkg::*;

    logic [31:0] drain_run_q, rec_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drain_run_q <= '0;
            rec_run_q   <= '0;
        end else begin
            drain_run_q <= (state_o == ST_DRAIN)   ? drain_run_q + 1 : '0;
            rec_run_q   <= (state_o == ST_RECOVER) ? rec_run_q + 1   : '0;
        end
    end

    // R7
    locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PROT || state_o == ST_RECOVER) |->
            (!ram_ce_o && !ram_we_o && !ram_oe_o && !dq_drive_o));

    // R2
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> ram_ce_o);

    // R2
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive_o |-> (ram_oe_o && !ram_we_o));

    // R6
    drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DRAIN) |-> (drain_run_q < T_WP));

    // R5
    drain_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DRAIN) |-> $past(host_ce_i));

    // R8
    recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORMAL && $past(state_o) == ST_RECOVER) |-> (rec_run_q == T_ER));

    // R8
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORMAL) |-> ($past(state_o) == ST_NORMAL || $past(state_o) == ST_RECOVER));
endmodule

bind pfail_guard pfail_guard_chk #(.T_WP(T_WP), .T_ER(T_ER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ce_i  (host_ce_i),
    .ram_ce_o   (ram_ce_o),
    .ram_we_o   (ram_we_o),
    .ram_oe_o   (ram_oe_o),
    .dq_drive_o (dq_drive_o),
    .state_o    (state_o)
);

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;
    localparam int T_WP = 4;
    localparam int T_ER = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desel = 1'b1, swo = 1'b0;
    logic ce = 1'b0, we = 1'b0, oe = 1'b0;
    logic ram_ce, ram_we, ram_oe, dq_drive, batt_sel;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfail_guard #(.T_WP(T_WP), .T_ER(T_ER)) u0 (
        .clk(clk), .rst_n(rst_n),
        .below_desel_i(desel), .below_swo_i(swo),
        .host_ce_i(ce), .host_we_i(we), .host_oe_i(oe),
        .ram_ce_o(ram_ce), .ram_we_o(ram_we), .ram_oe_o(ram_oe),
        .dq_drive_o(dq_drive), .batt_sel_o(batt_sel), .state_o(state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic d, input logic c, input logic w, input logic o);
        @(negedge clk);
        desel = d; ce = c; we = w; oe = o;
    endtask

    // packs ram_ce, ram_we, ram_oe, dq_drive
    function automatic logic [3:0] pins();
        return {ram_ce, ram_we, ram_oe, dq_drive};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        check("R1 state", state, 2);
        check("R1 pins", pins(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_power_up();
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        tick(2);
        check("R3 state before sync", state, 2);
        tick(1);
        check("R11 recover code", state, 3);
        check("R7 pins in recover", pins(), 4'b0000);
        tick(5);
        check("R8 still recovering", state, 3);
        tick(1);
        check("R8 normal after T_ER", state, 0);
        check("R2 write passes", pins(), 4'b1100);
    endtask

    task automatic t_pass();
        drive(1'b0, 1'b0, 1'b1, 1'b1); #1;
        check("R2 ce low", pins(), 4'b0000);
        drive(1'b0, 1'b1, 1'b0, 1'b1); #1;
        check("R2 read", pins(), 4'b1011);
        drive(1'b0, 1'b1, 1'b1, 1'b1); #1;
        check("R2 write with oe", pins(), 4'b1110);
        drive(1'b0, 1'b1, 1'b0, 1'b0); #1;
        check("R2 select only", pins(), 4'b1000);
    endtask

    task automatic restore();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick(9);
        check("R8 back to normal", state, 0);
    endtask

    task automatic t_fail_idle();
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick(2);
        check("R3 normal during sync", state, 0);
        tick(1);
        check("R4 protected", state, 2);
        drive(1'b1, 1'b1, 1'b1, 1'b1); #1;
        check("R7 inputs ignored", pins(), 4'b0000);
        restore();
    endtask

    task automatic t_drain_early();
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        tick(3);
        check("R5 drain code", state, 1);
        check("R5 read continues", pins(), 4'b1011);
        tick(1);
        check("R5 still draining", state, 1);
        drive(1'b1, 1'b0, 1'b0, 1'b1); #1;
        check("R12 drop same cycle", pins(), 4'b0000);
        tick(1);
        check("R12 protected after end", state, 2);
        drive(1'b1, 1'b1, 1'b0, 1'b1); #1;
        check("R12 new access blocked", pins(), 4'b0000);
        restore();
    endtask

    task automatic t_drain_timeout();
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        tick(3);
        check("R5 drain write", pins(), 4'b1100);
        tick(T_WP - 1);
        check("R6 drain at limit", state, 1);
        tick(1);
        check("R6 forced protect", state, 2);
        check("R6 write cut off", pins(), 4'b0000);
        restore();
    endtask

    task automatic t_recover_cancel();
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick(3);
        check("R4 protected again", state, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick(5);
        check("R9 recovering", state, 3);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick(2);
        check("R9 recover during sync", state, 3);
        tick(1);
        check("R9 back to protect", state, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick(8);
        check("R9 full restart", state, 3);
        tick(1);
        check("R9 normal after restart", state, 0);
    endtask

    task automatic t_battery();
        @(negedge clk); swo = 1'b1;
        tick(1);
        check("R10 batt not yet", batt_sel, 0);
        tick(1);
        check("R10 batt on", batt_sel, 1);
        @(negedge clk); swo = 1'b0;
        tick(1);
        check("R10 batt held", batt_sel, 1);
        tick(1);
        check("R10 batt off", batt_sel, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_pass();
        t_fail_idle();
        t_drain_early();
        t_drain_timeout();
        t_recover_cancel();
        t_battery();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule